// File: doc/BRIEF.md
# DMA Request Rate Limiter

This block sits between the request generator of one DMA channel and the system interconnect. It decides when a pending channel request may go out. After each granted request it holds further requests back until a programmed number of system clock cycles has passed. Each granted request carries one memory-side chunk of 1, 2, 4, 8, 16 or 32 bytes. The resulting throughput ceiling is the smaller of two figures: the clock rate times the bus width in bytes, and the clock rate times the chunk size divided by the spacing.

Software programs a 16-bit spacing value through a write strobe. Two values have special meanings. Zero removes all throttling, so requests pass as fast as the crossbar grants them. The all-ones value does not mean the longest gap: it stops the channel completely for as long as it stays programmed. The block does not move data, generate addresses, split bursts or arbitrate between channels. It only gates the request line and reports whether the channel is idle or being held back.

Top module: `rl_rate_limiter`

## Requirements
- R1: After reset the spacing value is 0, `dn_req` and `up_rdy` are low, `st_idle` is high and `st_blocked` is low.
- R2: With spacing 0, a raised `up_req` appears on `dn_req` in the same cycle, and grants may occur on consecutive cycles.
- R3: With spacing N (1 to 0xFFFE), two successive grants are at least N cycles apart. With `up_req` and `dn_gnt` held high, they are exactly N cycles apart.
- R4: The interval starts at the grant. A request raised while the interval is running keeps `dn_req` low and `st_blocked` high until the interval has run out.
- R5: While the spacing value is 0xFFFF, no new `dn_req` is raised, whatever the state of `up_req` and `dn_gnt`.
- R6: When 0xFFFF is replaced by any other value, a held `up_req` reaches `dn_req` in the first cycle after the write, with no further interval.
- R7: A spacing write made while an interval is running neither shortens nor lengthens that interval. The new value applies from the next grant on.
- R8: Once raised, `dn_req` stays high until a cycle in which `dn_gnt` is high, even if 0xFFFF is written meanwhile.
- R9: `up_rdy` is high exactly in the cycles where `dn_req` and `dn_gnt` are both high.
- R10: `st_idle` is high when `dn_req` is low and no interval is running. `st_blocked` is high when `up_req` is high and `dn_req` is low.
- R11: When a spacing write and a grant fall in the same cycle, the interval started by that grant uses the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Spacing register write strobe |
| cfg_wdata | input | 16 | Spacing value written when `cfg_wr` is high |
| up_req | input | 1 | Request from the channel, held until `up_rdy` |
| up_rdy | output | 1 | Tells the channel that its request was granted |
| dn_req | output | 1 | Request toward the crossbar |
| dn_gnt | input | 1 | Grant from the crossbar |
| st_idle | output | 1 | No request outstanding and no interval running |
| st_blocked | output | 1 | Channel request is being held back |

## Verification
`dn_req`, `up_rdy` and both status outputs follow the inputs within the same cycle. A spacing write counts from the next cycle. A grant in cycle t allows the next grant no earlier than cycle t+N. The bench drives inputs just after the rising edge and compares every output at the falling edge of the same cycle against a cycle model kept in the bench. Grant spacing is measured as a difference of cycle indices between observed grants, so each result is checked in the exact cycle it is due.

// File: rtl/rl_pkg.sv
// Package: shared types for the request rate limiter.
// Assumes: nothing beyond IEEE 1800-2017.
package rl_pkg;
    // Decoded meaning of the programmed spacing value
    typedef struct packed {
        logic halt;        // all-ones code: stop every request
        logic unthrottled; // zero: no spacing at all
    } rl_flags_t;
endpackage

// File: rtl/rl_spacing_reg.sv
// Module: rl_spacing_reg
// Holds the software-written spacing value and decodes its two special codes.
// Assumes: a write becomes visible in the cycle after the strobe.
module rl_spacing_reg
    import rl_pkg::*;
#(
    parameter int SPACE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SPACE_W-1:0] wr_data,
    output logic [SPACE_W-1:0] spacing,
    output rl_flags_t          flags
);
    localparam logic [SPACE_W-1:0] HALT_CODE = {SPACE_W{1'b1}};

    logic [SPACE_W-1:0] spacing_q;

    // Capture the written spacing value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spacing_q <= '0;
        end else if (wr_en) begin
            spacing_q <= wr_data;
        end
    end

    // Decode the special spacing codes
    always_comb begin
        flags.halt        = (spacing_q == HALT_CODE);
        flags.unthrottled = (spacing_q == '0);
    end

    assign spacing = spacing_q;
endmodule

// File: rtl/rl_gap_timer.sv
// Module: rl_gap_timer
// Counts down the gap that must follow a grant. With spacing N the next
// grant may come N cycles after this one, so the counter is loaded with N-1.
// Assumes: the halt code clears any running gap, so leaving halt needs no wait.
module rl_gap_timer
    import rl_pkg::*;
#(
    parameter int SPACE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SPACE_W-1:0] spacing,
    input  rl_flags_t          flags,
    output logic [SPACE_W-1:0] count,
    output logic               expired
);
    logic [SPACE_W-1:0] cnt_q;
    logic [SPACE_W-1:0] reload;

    // Reload value for a new gap
    always_comb begin
        reload = flags.unthrottled ? '0 : spacing - 1'b1;
    end

    // Load on grant, count down otherwise, clear while halted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (flags.halt) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= reload;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count   = cnt_q;
    assign expired = (cnt_q == '0);
endmodule

// File: rtl/rl_req_gate.sv
// Module: rl_req_gate
// Passes the channel request downstream when the gate is open and keeps
// a raised downstream request up until it is granted.
// Assumes: the channel holds up_req until up_rdy.
module rl_req_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic up_req,
    input  logic open,
    input  logic dn_gnt,
    output logic dn_req,
    output logic up_rdy,
    output logic blocked
);
    logic pend_q;

    // Remember a raised request that was not yet granted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= dn_req & ~dn_gnt;
        end
    end

    // Request, acknowledge and hold-back status
    always_comb begin
        dn_req  = pend_q | (up_req & open);
        up_rdy  = dn_req & dn_gnt;
        blocked = up_req & ~dn_req;
    end
endmodule

// File: rtl/rl_rate_limiter.sv
// Module: rl_rate_limiter (top)
// Enforces a programmable minimum number of clock cycles between granted
// requests of one DMA channel. Spacing 0 means unthrottled, all-ones halts.
// Assumes: a single clock domain and synchronous active-low reset.
module rl_rate_limiter
    import rl_pkg::*;
#(
    parameter int SPACE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [SPACE_W-1:0] cfg_wdata,
    input  logic               up_req,
    output logic               up_rdy,
    output logic               dn_req,
    input  logic               dn_gnt,
    output logic               st_idle,
    output logic               st_blocked
);
    logic [SPACE_W-1:0] spacing_q;
    logic [SPACE_W-1:0] gap_cnt;
    rl_flags_t          flags;
    logic               gap_done;
    logic               gate_open;
    logic               granted;

    rl_spacing_reg #(.SPACE_W(SPACE_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_data (cfg_wdata),
        .spacing (spacing_q),
        .flags   (flags)
    );

    rl_gap_timer #(.SPACE_W(SPACE_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (granted),
        .spacing (spacing_q),
        .flags   (flags),
        .count   (gap_cnt),
        .expired (gap_done)
    );

    rl_req_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .up_req  (up_req),
        .open    (gate_open),
        .dn_gnt  (dn_gnt),
        .dn_req  (dn_req),
        .up_rdy  (up_rdy),
        .blocked (st_blocked)
    );

    // Gate opens once the gap ran out and the channel is not halted
    always_comb begin
        gate_open = gap_done & ~flags.halt;
        granted   = dn_req & dn_gnt;
        st_idle   = ~dn_req & gap_done;
    end
endmodule

// File: rtl/rl_rate_limiter_chk.sv
// Module: rl_rate_limiter_chk
// Temporal checks on the rate limiter, bound into every instance of the top.
module rl_rate_limiter_chk #(
    parameter int SPACE_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_wr,
    input logic               dn_req,
    input logic               dn_gnt,
    input logic [SPACE_W-1:0] spacing_q,
    input logic [SPACE_W-1:0] gap_cnt
);
    localparam logic [SPACE_W-1:0] HALT_CODE = {SPACE_W{1'b1}};

    // R8: a raised request is held until granted
    p_hold_until_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && !dn_gnt) |=> dn_req);

    // R4: no downstream request while a gap is running
    p_quiet_in_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_cnt != '0) |-> !dn_req);

    // R5: halt code keeps a low request low unless the value is rewritten
    p_halt_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (spacing_q == HALT_CODE && !dn_req && !cfg_wr) |=> !dn_req);

    // R6: halt clears any running gap
    p_halt_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (spacing_q == HALT_CODE) |=> (gap_cnt == '0));

    // R7, R11: a grant starts a gap from the value held in that cycle
    p_grant_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && dn_gnt && spacing_q != HALT_CODE && spacing_q != '0)
        |=> (gap_cnt == $past(spacing_q) - 1'b1));

    // R3: a running gap counts down by one per cycle
    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_cnt != '0 && spacing_q != HALT_CODE)
        |=> (gap_cnt == $past(gap_cnt) - 1'b1));
endmodule

bind rl_rate_limiter rl_rate_limiter_chk #(.SPACE_W(SPACE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .dn_req    (dn_req),
    .dn_gnt    (dn_gnt),
    .spacing_q (spacing_q),
    .gap_cnt   (gap_cnt)
);

// File: tb/rl_rate_limiter_tb_top.sv
// Bench: rl_rate_limiter_tb_top
// Directed corner cases followed by seeded random traffic; every cycle the
// outputs are compared with a cycle model kept in the bench.
module rl_rate_limiter_tb_top;
    localparam int W = 16;
    localparam logic [W-1:0] HALT = 16'hFFFF;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wr = 1'b0;
    logic [W-1:0] cfg_wdata = '0;
    logic         up_req = 1'b0;
    logic         up_rdy;
    logic         dn_req;
    logic         dn_gnt = 1'b0;
    logic         st_idle;
    logic         st_blocked;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    // model state
    logic [W-1:0] m_spc = '0;
    int           m_rem = 0;
    bit           m_pend = 0;

    // last observed outputs
    bit o_dn, o_rdy, o_blk, g_seen;

    rl_rate_limiter #(.SPACE_W(W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .up_req     (up_req),
        .up_rdy     (up_rdy),
        .dn_req     (dn_req),
        .dn_gnt     (dn_gnt),
        .st_idle    (st_idle),
        .st_blocked (st_blocked)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cycle %0d actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    function automatic bit exp_dn_f();
        return m_pend || (up_req && m_rem == 0 && m_spc != HALT);
    endfunction

    // One cycle: compare at the falling edge, advance the model, return after the rising edge
    task automatic step();
        bit e_dn;
        bit gr;
        @(negedge clk);
        e_dn = exp_dn_f();
        o_dn = dn_req; o_rdy = up_rdy; o_blk = st_blocked;
        g_seen = dn_req && dn_gnt;
        check(dn_req == e_dn, "R4 dn_req", dn_req, e_dn);
        check(up_rdy == (e_dn && dn_gnt), "R9 up_rdy", up_rdy, e_dn && dn_gnt);
        check(st_blocked == (up_req && !e_dn), "R10 st_blocked", st_blocked, up_req && !e_dn);
        check(st_idle == (!e_dn && m_rem == 0), "R10 st_idle", st_idle, !e_dn && m_rem == 0);
        gr = e_dn && dn_gnt;
        if (m_spc == HALT) m_rem = 0;
        else if (gr) m_rem = (m_spc == 0) ? 0 : int'(m_spc) - 1;
        else if (m_rem > 0) m_rem--;
        m_pend = e_dn && !dn_gnt;
        if (cfg_wr) m_spc = cfg_wdata;
        @(posedge clk);
        #1;
        cyc++;
    endtask

    task automatic write_spc(input logic [W-1:0] v);
        cfg_wr = 1'b1; cfg_wdata = v;
        step();
        cfg_wr = 1'b0;
    endtask

    task automatic wait_grant(output int at);
        at = -1;
        for (int i = 0; i < 100; i++) begin
            step();
            if (g_seen) begin at = cyc - 1; break; end
        end
    endtask

    initial begin
        int g0, g1, g2, prev;
        bit bad;
        void'($urandom(32'h1234_5EED));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check(!dn_req && !up_rdy && st_idle && !st_blocked, "R1 reset outputs",
              {dn_req, up_rdy, st_idle, st_blocked}, 4'b0010);
        @(posedge clk); #1;

        // R2: spacing 0 allows back-to-back grants
        up_req = 1'b1; dn_gnt = 1'b1;
        bad = 0;
        for (int i = 0; i < 8; i++) begin step(); if (!o_rdy) bad = 1; end
        check(!bad, "R2 back-to-back grants", bad, 0);

        // R3: exact spacing of 5 under continuous demand
        write_spc(16'd5);
        prev = -1;
        for (int i = 0; i < 30; i++) begin
            step();
            if (g_seen) begin
                if (prev >= 0) check(cyc - 1 - prev == 5, "R3 grant gap", cyc - 1 - prev, 5);
                prev = cyc - 1;
            end
        end

        // R4: request raised during the gap waits for its end
        wait_grant(g0);
        up_req = 1'b0;
        step(); step();
        up_req = 1'b1;
        step();
        check(!o_dn && o_blk, "R4 held in gap", {o_dn, o_blk}, 2'b01);
        wait_grant(g1);
        check(g1 - g0 == 5, "R4 grant after gap", g1 - g0, 5);

        // R7: a write mid-gap neither shortens nor extends it
        write_spc(16'd20);
        wait_grant(g0);
        wait_grant(g0);
        step(); step();
        write_spc(16'd2);
        wait_grant(g1);
        check(g1 - g0 == 20, "R7 gap kept", g1 - g0, 20);
        wait_grant(g2);
        check(g2 - g1 == 2, "R7 new value next", g2 - g1, 2);

        // R11: write in the grant cycle uses the old value
        write_spc(16'd10);
        wait_grant(g0);
        wait_grant(g0);
        for (int i = 0; i < 9; i++) step();
        write_spc(16'd3);
        check(g_seen == 1'b1, "R11 grant in write cycle", g_seen, 1);
        g1 = cyc - 1;
        wait_grant(g2);
        check(g2 - g1 == 10, "R11 old value used", g2 - g1, 10);
        wait_grant(g0);
        check(g0 - g2 == 3, "R11 new value after", g0 - g2, 3);

        // R5: halt code stops all requests
        dn_gnt = 1'b1; up_req = 1'b1;
        write_spc(HALT);
        step();
        bad = 0;
        for (int i = 0; i < 40; i++) begin step(); if (o_dn || !o_blk) bad = 1; end
        check(!bad, "R5 halted", bad, 0);

        // R6: leaving halt resumes at once
        write_spc(16'd7);
        check(!o_dn, "R6 still halted in write cycle", o_dn, 0);
        step();
        check(o_dn && g_seen, "R6 immediate resume", o_dn, 1);

        // R8: raised request stays up across a halt write
        for (int i = 0; i < 8; i++) step();
        dn_gnt = 1'b0;
        wait_grant(g0);
        step();
        check(o_dn, "R8 request raised", o_dn, 1);
        write_spc(HALT);
        bad = 0;
        for (int i = 0; i < 5; i++) begin step(); if (!o_dn || o_rdy) bad = 1; end
        check(!bad, "R8 held until grant", bad, 0);
        dn_gnt = 1'b1;
        step();
        check(o_rdy, "R8 granted", o_rdy, 1);
        up_req = 1'b0;
        step();
        check(!o_dn, "R8 dropped after grant", o_dn, 0);
        write_spc(16'd0);

        // Random traffic against the cycle model
        for (int i = 0; i < 3000; i++) begin
            dn_gnt = ($urandom % 4) != 0;
            if (!up_req || o_rdy) up_req = ($urandom % 3) == 0;
            if (($urandom % 40) == 0) begin
                case ($urandom % 4)
                    0: cfg_wdata = 16'd0;
                    1: cfg_wdata = HALT;
                    2: cfg_wdata = 16'd1;
                    default: cfg_wdata = 16'($urandom % 12);
                endcase
                cfg_wr = 1'b1;
            end else begin
                cfg_wr = 1'b0;
            end
            step();
        end
        cfg_wr = 1'b0;

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule